// File: doc/BRIEF.md
# Serial Byte Receiver with Request/Acknowledge Hand-off

This block recovers bytes from an asynchronous serial line that idles high. A frame carries a low start bit, eight data bits sent least-significant first, one odd-parity bit, and a high stop bit. The line rate and the system clock frequency are parameters. The defaults are 19,200 baud from a 100 MHz clock, which gives 5208 clocks per bit and 2604 clocks to mid-bit. The line passes through a two-flop synchronizer. A falling edge seen while idle starts a frame. The receiver waits half a bit to reach the centre of the start bit. It then waits one full bit before each later sample, so every bit is taken at its centre.

The data and parity bits go into a nine-bit right-shifting register. Its low eight bits drive the byte output. Once the centre of the stop bit is reached, the receiver raises a request to the host and keeps it high until the host acknowledges. It then drops the request and waits for the acknowledge to fall before it looks for the next frame. A parity error flag is valid only while the request is high.

Top module: `uart_byte_rx`

## Requirements
- R1: While synchronous active-high reset is applied, and on the cycle after it, `byte_req_o` and `parity_err_o` are low.
- R2: Each bit is sampled near its centre. A frame is received correctly even when the line holds the wrong value for the first 3 and the last 3 clocks of every data and parity bit.
- R3: Bits arrive least-significant first, and `byte_o[0]` holds the first data bit after the start bit.
- R4: With odd parity, `parity_err_o` is high while `byte_req_o` is high exactly when the nine received bits (data plus parity) contain an even number of ones.
- R5: `parity_err_o` is low whenever `byte_req_o` is low.
- R6: `byte_req_o` rises exactly HALF + 10*BIT + 3 clocks after the line's falling start edge. BIT is CLK_FREQ_HZ/BAUD_RATE and HALF is BIT/2. This places the rise at the centre of the stop bit plus the synchronizer and state latency.
- R7: `byte_req_o` stays high while `byte_ack_i` is low, and `byte_o` and `parity_err_o` stay unchanged during that time.
- R8: One clock after `byte_ack_i` is seen high with the request up, `byte_req_o` falls. No new frame is accepted until `byte_ack_i` is low again: a frame sent while the acknowledge stays high raises no request and leaves `byte_o` unchanged.
- R9: The bit timer never signals half-bit and full-bit in the same cycle. The half-bit mark does not restart its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| serial_i | input | 1 | Asynchronous serial line, idle high |
| byte_req_o | output | 1 | High while a received byte waits for the host |
| byte_ack_i | input | 1 | Host acknowledge of the offered byte |
| byte_o | output | 8 | Received data byte |
| parity_err_o | output | 1 | Parity failure of the offered byte, valid with the request |

## Verification
The assertions assume a four-phase host. The host raises the acknowledge only while the request is up and holds it until the request has dropped. They also assume that no start edge arrives while a hand-off is pending, except in the one scenario that deliberately sends a frame while the acknowledge is held high. The bench keeps within these rules. It drives every frame bit for exactly BIT clocks, and it corrupts only the edges of bits, never their centres. Every acknowledge sequence waits for the request to fall before it releases.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    // Receiver control states
    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_HOLD,
        RX_RELEASE
    } rx_state_e;

    // Data bits plus one parity bit
    localparam int unsigned RX_DATA_BITS  = 8;
    localparam int unsigned RX_FRAME_BITS = RX_DATA_BITS + 1;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync (
    input  logic clk_i,
    input  logic rst_i,
    input  logic serial_i,
    output logic level_o,
    output logic fell_o
);
    // Two metastability flops plus one history flop for edge detection
    logic [2:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[1:0], serial_i};
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) sync_q <= 3'b111;
        else       sync_q <= sync_d;
    end

    assign level_o = sync_q[1];
    assign fell_o  = sync_q[2] & ~sync_q[1];
endmodule

// File: rtl/rx_bit_timer.sv
module rx_bit_timer #(
    parameter int unsigned BIT_CYC  = 5208,
    parameter int unsigned HALF_CYC = 2604
) (
    input  logic clk_i,
    input  logic clr_i,
    output logic half_o,
    output logic full_o
);
    localparam int unsigned CW = (BIT_CYC > 1) ? $clog2(BIT_CYC) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    // The half mark is only a tap; the count runs on to the full period
    assign half_o = (cnt_q == CW'(HALF_CYC - 1));
    assign full_o = (cnt_q == CW'(BIT_CYC - 1));

    always_comb begin
        if (clr_i || full_o) cnt_d = '0;
        else                 cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i) begin
        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rx_frame_shift.sv
module rx_frame_shift #(
    parameter int unsigned WIDTH = 9
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             shift_i,
    input  logic             bit_i,
    output logic [WIDTH-1:0] word_o,
    output logic             odd_o
);
    logic [WIDTH-1:0] word_d, word_q;

    // New samples enter at the top; the first bit ends at position 0
    always_comb begin
        word_d = word_q;
        if (shift_i) word_d = {bit_i, word_q[WIDTH-1:1]};
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) word_q <= '0;
        else       word_q <= word_d;
    end

    assign word_o = word_q;
    assign odd_o  = ^word_q;
endmodule

// File: rtl/uart_byte_rx.sv
module uart_byte_rx #(
    parameter int unsigned CLK_FREQ_HZ = 100_000_000,
    parameter int unsigned BAUD_RATE   = 19_200
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       serial_i,
    output logic       byte_req_o,
    input  logic       byte_ack_i,
    output logic [7:0] byte_o,
    output logic       parity_err_o
);
    import uart_rx_pkg::*;

    localparam int unsigned BIT_CYC  = CLK_FREQ_HZ / BAUD_RATE;
    localparam int unsigned HALF_CYC = BIT_CYC / 2;
    localparam int unsigned BCW      = $clog2(RX_FRAME_BITS);

    typedef struct packed {
        rx_state_e      state;
        logic [BCW-1:0] bitcnt;
        logic           perr;
    } rx_ctl_t;

    rx_ctl_t ctl_d, ctl_q;

    logic line_lvl, line_fell;
    logic half_tick, full_tick;
    logic tmr_clr, shift_en;
    logic [RX_FRAME_BITS-1:0] frame_word;
    logic frame_odd;

    rx_line_sync sync_i (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .serial_i (serial_i),
        .level_o  (line_lvl),
        .fell_o   (line_fell)
    );

    rx_bit_timer #(
        .BIT_CYC  (BIT_CYC),
        .HALF_CYC (HALF_CYC)
    ) timer_i (
        .clk_i  (clk_i),
        .clr_i  (tmr_clr),
        .half_o (half_tick),
        .full_o (full_tick)
    );

    rx_frame_shift #(
        .WIDTH (RX_FRAME_BITS)
    ) shreg_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .shift_i (shift_en),
        .bit_i   (line_lvl),
        .word_o  (frame_word),
        .odd_o   (frame_odd)
    );

    always_comb begin
        ctl_d    = ctl_q;
        tmr_clr  = rst_i;
        shift_en = 1'b0;
        unique case (ctl_q.state)
            RX_IDLE: begin
                tmr_clr      = 1'b1;
                ctl_d.bitcnt = '0;
                ctl_d.perr   = 1'b0;
                if (line_fell) ctl_d.state = RX_START;
            end
            RX_START: begin
                if (half_tick) begin
                    tmr_clr     = 1'b1;
                    ctl_d.state = RX_DATA;
                end
            end
            RX_DATA: begin
                if (full_tick) begin
                    shift_en = 1'b1;
                    if (ctl_q.bitcnt == BCW'(RX_FRAME_BITS - 1)) ctl_d.state = RX_STOP;
                    else ctl_d.bitcnt = ctl_q.bitcnt + 1'b1;
                end
            end
            RX_STOP: begin
                if (full_tick) begin
                    ctl_d.perr  = ~frame_odd;
                    ctl_d.state = RX_HOLD;
                end
            end
            RX_HOLD: begin
                if (byte_ack_i) begin
                    ctl_d.perr  = 1'b0;
                    ctl_d.state = RX_RELEASE;
                end
            end
            RX_RELEASE: begin
                if (!byte_ack_i) ctl_d.state = RX_IDLE;
            end
            default: ctl_d.state = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctl_q.state  <= RX_IDLE;
            ctl_q.bitcnt <= '0;
            ctl_q.perr   <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign byte_req_o   = (ctl_q.state == RX_HOLD);
    assign parity_err_o = ctl_q.perr;
    assign byte_o       = frame_word[RX_DATA_BITS-1:0];
endmodule

// File: rtl/uart_byte_rx_chk.sv
module uart_byte_rx_chk (
    input logic       clk_i,
    input logic       rst_i,
    input logic       byte_req_o,
    input logic       byte_ack_i,
    input logic [7:0] byte_o,
    input logic       parity_err_o,
    input logic       half_tick,
    input logic       full_tick
);
    // R1: outputs quiet straight after reset
    a_r1_reset_quiet: assert property (@(posedge clk_i)
        rst_i |=> (!byte_req_o && !parity_err_o));

    // R5: error flag only alongside the request
    a_r5_perr_qualified: assert property (@(posedge clk_i) disable iff (rst_i)
        !byte_req_o |-> !parity_err_o);

    // R7: request held until acknowledged
    a_r7_req_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        (byte_req_o && !byte_ack_i) |=> byte_req_o);

    // R7: offered byte and flag stable while offered
    a_r7_data_stable: assert property (@(posedge clk_i) disable iff (rst_i)
        (byte_req_o && !byte_ack_i) |=> ($stable(byte_o) && $stable(parity_err_o)));

    // R8: request drops one clock after acknowledge
    a_r8_req_drop: assert property (@(posedge clk_i) disable iff (rst_i)
        (byte_req_o && byte_ack_i) |=> !byte_req_o);

    // R8: a new request never rises while the old acknowledge is still high
    a_r8_no_rise_under_ack: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(byte_req_o) |-> !byte_ack_i);

    // R9: half and full marks never coincide
    a_r9_ticks_exclusive: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0({half_tick, full_tick}));
endmodule

bind uart_byte_rx uart_byte_rx_chk chk_i (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .byte_req_o   (byte_req_o),
    .byte_ack_i   (byte_ack_i),
    .byte_o       (byte_o),
    .parity_err_o (parity_err_o),
    .half_tick    (half_tick),
    .full_tick    (full_tick)
);

// File: tb/uart_byte_rx_tb_top.sv
module uart_byte_rx_tb_top;
    localparam int unsigned CLK_HZ = 160;
    localparam int unsigned BAUD   = 10;
    localparam int BIT  = CLK_HZ / BAUD;
    localparam int HALF = BIT / 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       serial = 1'b1;
    logic       ack = 1'b0;
    logic       req;
    logic [7:0] dout;
    logic       perr;

    int errs = 0;
    int checks = 0;

    always #4 clk = ~clk;

    uart_byte_rx #(
        .CLK_FREQ_HZ (CLK_HZ),
        .BAUD_RATE   (BAUD)
    ) dut_i (
        .clk_i        (clk),
        .rst_i        (rst),
        .serial_i     (serial),
        .byte_req_o   (req),
        .byte_ack_i   (ack),
        .byte_o       (dout),
        .parity_err_o (perr)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drives one frame; returns clocks from start edge to request rise (-1 if none)
    task automatic send_frame(input logic [7:0] d, input bit bad, input bit glitch, output int lat);
        logic [10:0] fr;
        lat = -1;
        fr = {1'b1, (~^d) ^ bad, d, 1'b0};
        for (int i = 0; i < 11 * BIT; i++) begin
            int b;
            int off;
            logic v;
            @(negedge clk);
            if (lat < 0 && req) lat = i;
            b = i / BIT;
            off = i % BIT;
            v = fr[b];
            if (glitch && b >= 1 && b <= 9 && (off < 3 || off >= BIT - 3)) v = ~v;
            serial = v;
        end
        serial = 1'b1;
        for (int i = 11 * BIT; i < 15 * BIT; i++) begin
            if (lat >= 0) break;
            @(negedge clk);
            if (req) lat = i;
        end
    endtask

    task automatic handshake(input string tag);
        @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        chk(req == 1'b0, {tag, " R8 req drop"}, req, 0);
        chk(perr == 1'b0, {tag, " R5 perr low"}, perr, 0);
        ack = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (4) @(negedge clk);
        chk(req == 1'b0, "R1 req in reset", req, 0);
        chk(perr == 1'b0, "R1 perr in reset", perr, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(req == 1'b0, "R1 req after reset", req, 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_byte(input logic [7:0] d, input bit bad, input bit glitch, input string tag);
        int lat;
        send_frame(d, bad, glitch, lat);
        chk(lat >= 0, {tag, " R3 request seen"}, lat, 1);
        chk(dout == d, glitch ? {tag, " R2 glitched data"} : {tag, " R3 data"}, dout, d);
        chk(perr == bad, {tag, " R4 parity flag"}, perr, bad);
        if (!glitch) chk(lat == HALF + 10 * BIT + 3, {tag, " R6 latency"}, lat, HALF + 10 * BIT + 3);
        handshake(tag);
    endtask

    task automatic t_hold();
        int lat;
        send_frame(8'h3C, 1'b1, 1'b0, lat);
        repeat (50) @(negedge clk);
        chk(req == 1'b1, "R7 req held", req, 1);
        chk(dout == 8'h3C, "R7 data held", dout, 8'h3C);
        chk(perr == 1'b1, "R7 flag held", perr, 1);
        handshake("hold");
    endtask

    task automatic t_ack_block();
        int lat;
        send_frame(8'h96, 1'b0, 1'b0, lat);
        @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        chk(req == 1'b0, "R8 drop on ack", req, 0);
        send_frame(8'hC3, 1'b0, 1'b0, lat);
        chk(lat < 0, "R8 no request under ack", lat, -1);
        chk(dout == 8'h96, "R8 data untouched", dout, 8'h96);
        ack = 1'b0;
        repeat (3) @(negedge clk);
        t_byte(8'h11, 1'b0, 1'b0, "after release");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_byte(8'h59, 1'b0, 1'b0, "good 59");
        t_byte(8'h59, 1'b1, 1'b0, "bad 59");
        t_byte(8'h00, 1'b0, 1'b0, "good 00");
        t_byte(8'hFF, 1'b0, 1'b0, "good FF");
        t_byte(8'h01, 1'b0, 1'b0, "lsb 01");
        t_byte(8'hA5, 1'b0, 1'b1, "edges A5");
        t_byte(8'h6E, 1'b1, 1'b1, "edges 6E");
        t_hold();
        t_ack_block();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule